// File: doc/BRIEF.md
# Latched Alarm Status Register with Change Interrupt

This block collects seven framer alarm and event conditions and latches each into a read-only status bit. The conditions are loss of signal, loss of frame, incoming alarm indication, remote alarm, idle pattern detect, and the transmit and receive start-of-frame events. Software reads the status word through a simple register read port. A status bit survives the clear-on-read for as long as its condition is still present, so a persistent alarm cannot be lost between polls.

Every change of a condition raises an interrupt, whether the condition asserts or deasserts. The interrupt passes only when the bit's own enable in a per-bit mask register is one and the single enable in a master mask register is also one. The interrupt output is an active-high registered level. It stays high until software reads the status word.

The read port has no back-pressure. `rd_vld_o` and `rd_data_o` come exactly one cycle after `rd_en_i`, and the consumer must take them in that cycle. Writes to the masks complete in the cycle they are presented.

Top module: `alarm_status_irq`

## Requirements
- R1: After reset all status bits, pending flags, the per-bit mask and the master mask are zero, and `irq_o` is low.
- R2: A read at address 0x12 returns the status word one cycle after `rd_en_i`, with `rd_vld_o` high for that one cycle. The bit positions are: loss of signal bit 0, loss of frame bit 1, alarm indication bit 2, remote alarm bit 3, idle bit 4, transmit start-of-frame bit 5, receive start-of-frame bit 6. Bits 15 to 7 read as zero. Unmapped addresses read as zero.
- R3: A status bit becomes one at the first clock edge where its condition input is high. It stays one until a status read.
- R4: A status read at 0x12 clears every status bit whose condition is low at that edge. A bit whose condition is high at that edge stays one.
- R5: A rising or a falling change of a condition input, compared with its value on the previous cycle, marks that bit pending and drives `irq_o` high after the same edge.
- R6: A change marks nothing pending unless its bit is one in the per-bit mask and the master mask is one. `irq_o` stays low while the master mask was zero on the previous cycle.
- R7: A status read clears all pending flags, and `irq_o` falls after that edge. A change in the same cycle as the read still becomes pending, and its status bit still latches.
- R8: The per-bit mask is read-write at 0x13 (bits 6:0, bit n enables status bit n). The master mask is read-write at 0x14 (bit 0). Both read back one cycle after the read.
- R9: `irq_o` holds high across cycles with no read, for as long as any pending flag has its mask bit enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock; condition inputs are synchronous to it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 7 | Live condition levels or pulses, positions as in R2 |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_vld_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | 16 | Read data |
| wr_en_i | input | 1 | Write strobe for the mask registers |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 7 | Write data |
| irq_o | output | 1 | Registered active-high interrupt level |

## Verification
A condition change driven before a clock edge sets the status bit, the pending flag and `irq_o` at that same edge, so `irq_o` is sampled on the falling edge that follows. Read data is registered. The bench therefore pushes each expected word into a queue when it issues the strobe, and pops it on the falling edge where `rd_vld_o` is seen. The pending clear caused by a read shows on `irq_o` at that same falling edge. The same-cycle read-and-change case is checked in exactly that window.

// File: rtl/alarm_status_pkg.sv
package alarm_status_pkg;
  localparam int unsigned ALM_W_DEF  = 7;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam logic [7:0]  STS_ADDR_DEF = 8'h12;
  localparam logic [7:0]  MSK_ADDR_DEF = 8'h13;
  localparam logic [7:0]  MST_ADDR_DEF = 8'h14;

  typedef enum int unsigned {
    ALM_SIG_LOSS = 0,
    ALM_FRM_LOSS = 1,
    ALM_AIS      = 2,
    ALM_REMOTE   = 3,
    ALM_IDLE     = 4,
    ALM_TX_SOF   = 5,
    ALM_RX_SOF   = 6
  } alm_idx_e;
endpackage

// File: rtl/alarm_bit_cell.sv
module alarm_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic clr_i,
  input  logic en_i,
  output logic sts_o,
  output logic chg_o,
  output logic pend_nxt_o
);
  logic cond_q;
  logic sts_q;
  logic pend_q;

  assign chg_o      = cond_i ^ cond_q;
  assign pend_nxt_o = (clr_i ? 1'b0 : pend_q) | (chg_o & en_i);
  assign sts_o      = sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      sts_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      pend_q <= pend_nxt_o;
      if (clr_i) sts_q <= cond_i;
      else       sts_q <= sts_q | cond_i;
    end
  end
endmodule

// File: rtl/alarm_mask_regs.sv
module alarm_mask_regs #(
  parameter int unsigned ALM_W    = alarm_status_pkg::ALM_W_DEF,
  parameter int unsigned ADDR_W   = alarm_status_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] MSK_ADDR = alarm_status_pkg::MSK_ADDR_DEF,
  parameter logic [ADDR_W-1:0] MST_ADDR = alarm_status_pkg::MST_ADDR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ALM_W-1:0]  wr_data_i,
  output logic [ALM_W-1:0]  bit_mask_o,
  output logic              master_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_mask_o <= '0;
      master_o   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == MSK_ADDR) bit_mask_o <= wr_data_i;
      if (wr_addr_i == MST_ADDR) master_o   <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/alarm_read_port.sv
module alarm_read_port #(
  parameter int unsigned ALM_W    = alarm_status_pkg::ALM_W_DEF,
  parameter int unsigned DATA_W   = alarm_status_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W   = alarm_status_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] STS_ADDR = alarm_status_pkg::STS_ADDR_DEF,
  parameter logic [ADDR_W-1:0] MSK_ADDR = alarm_status_pkg::MSK_ADDR_DEF,
  parameter logic [ADDR_W-1:0] MST_ADDR = alarm_status_pkg::MST_ADDR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ALM_W-1:0]  sts_i,
  input  logic [ALM_W-1:0]  bit_mask_i,
  input  logic              master_i,
  output logic              sts_clr_o,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - ALM_W;

  logic [DATA_W-1:0] mux_d;

  assign sts_clr_o = rd_en_i && (rd_addr_i == STS_ADDR);

  always_comb begin
    mux_d = '0;
    if (rd_addr_i == STS_ADDR)      mux_d = {{PAD_W{1'b0}}, sts_i};
    else if (rd_addr_i == MSK_ADDR) mux_d = {{PAD_W{1'b0}}, bit_mask_i};
    else if (rd_addr_i == MST_ADDR) mux_d = {{(DATA_W-1){1'b0}}, master_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mux_d;
    end
  end
endmodule

// File: rtl/alarm_status_irq.sv
module alarm_status_irq #(
  parameter int unsigned ALM_W    = alarm_status_pkg::ALM_W_DEF,
  parameter int unsigned DATA_W   = alarm_status_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W   = alarm_status_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] STS_ADDR = alarm_status_pkg::STS_ADDR_DEF,
  parameter logic [ADDR_W-1:0] MSK_ADDR = alarm_status_pkg::MSK_ADDR_DEF,
  parameter logic [ADDR_W-1:0] MST_ADDR = alarm_status_pkg::MST_ADDR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ALM_W-1:0]  alarm_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ALM_W-1:0]  wr_data_i,
  output logic              irq_o
);
  logic [ALM_W-1:0] sts_w;
  logic [ALM_W-1:0] chg_w;
  logic [ALM_W-1:0] pend_nxt_w;
  logic [ALM_W-1:0] bit_mask_w;
  logic             master_w;
  logic             sts_clr_w;
  logic             irq_q;

  alarm_mask_regs #(
    .ALM_W(ALM_W), .ADDR_W(ADDR_W), .MSK_ADDR(MSK_ADDR), .MST_ADDR(MST_ADDR)
  ) u_masks (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .bit_mask_o(bit_mask_w), .master_o(master_w)
  );

  alarm_read_port #(
    .ALM_W(ALM_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STS_ADDR(STS_ADDR), .MSK_ADDR(MSK_ADDR), .MST_ADDR(MST_ADDR)
  ) u_rdport (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .sts_i(sts_w), .bit_mask_i(bit_mask_w), .master_i(master_w),
    .sts_clr_o(sts_clr_w), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
  );

  for (genvar gi = 0; gi < ALM_W; gi++) begin : g_cell
    alarm_bit_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(alarm_i[gi]), .clr_i(sts_clr_w),
      .en_i(bit_mask_w[gi] & master_w), .sts_o(sts_w[gi]), .chg_o(chg_w[gi]),
      .pend_nxt_o(pend_nxt_w[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= master_w & (|(pend_nxt_w & bit_mask_w));
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/alarm_status_irq_chk.sv
module alarm_status_irq_chk #(
  parameter int unsigned ALM_W  = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ALM_W-1:0]  alarm_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_vld_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_en_i,
  input logic              irq_o,
  input logic [ALM_W-1:0]  sts_w,
  input logic [ALM_W-1:0]  chg_w,
  input logic [ALM_W-1:0]  bit_mask_w,
  input logic              master_w
);
  logic sts_rd;
  assign sts_rd = rd_en_i && (rd_addr_i == STS_ADDR);

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (rd_data_o[DATA_W-1:ALM_W] == '0)); // R2

  AST_STATUS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|alarm_i) |=> ((sts_w & $past(alarm_i)) == $past(alarm_i))); // R3

  AST_READ_CLEARS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rd |=> ((sts_w & ~$past(alarm_i)) == '0)); // R4

  AST_CHANGE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(chg_w & bit_mask_w)) && master_w && !wr_en_i) |=> irq_o); // R5

  AST_MASTER_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(master_w) |-> !irq_o); // R6

  AST_READ_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_rd && (chg_w == '0)) |=> !irq_o); // R7
endmodule

bind alarm_status_irq alarm_status_irq_chk #(
  .ALM_W(ALM_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alarm_i(alarm_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o),
  .wr_en_i(wr_en_i), .irq_o(irq_o), .sts_w(sts_w), .chg_w(chg_w),
  .bit_mask_w(bit_mask_w), .master_w(master_w)
);

// File: tb/alarm_status_irq_bench.sv
module alarm_status_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  alarm = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        rd_vld;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [6:0]  wr_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] A_STS = 8'h12;
  localparam logic [7:0] A_MSK = 8'h13;
  localparam logic [7:0] A_MST = 8'h14;

  always #10 clk = ~clk;

  alarm_status_irq u_alarm_status_irq (
    .clk_i(clk), .rst_ni(rst_n), .alarm_i(alarm), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_vld_o(rd_vld), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .irq_o(irq)
  );

  // monitor: pops expected read words as results appear
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read data got %h exp none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: read got %h exp %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [15:0] e, input string t);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b exp %b", t, irq, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_irq(1'b0, "R1");
    do_read(A_STS, 16'h0000, "R1");
    do_read(A_MSK, 16'h0000, "R1");
    do_read(A_MST, 16'h0000, "R1");

    // R3: one-cycle pulse on loss of signal is latched
    alarm[0] = 1'b1; step(); alarm[0] = 1'b0; step();
    do_read(A_STS, 16'h0001, "R3");
    do_read(A_STS, 16'h0000, "R4");

    // R4: a held condition survives the clear-on-read
    alarm[1] = 1'b1; step();
    do_read(A_STS, 16'h0002, "R4");
    do_read(A_STS, 16'h0002, "R4");
    alarm[1] = 1'b0; step();
    do_read(A_STS, 16'h0002, "R3");
    do_read(A_STS, 16'h0000, "R4");
    do_read(8'h20, 16'h0000, "R2");

    // R8: mask registers read back
    do_write(A_MSK, 7'h7F);
    do_write(A_MST, 7'h01);
    do_read(A_MSK, 16'h007F, "R8");
    do_read(A_MST, 16'h0001, "R8");
    chk_irq(1'b0, "R6");

    // R5, R9, R7: rising then falling change on the alarm indication bit
    alarm[2] = 1'b1; step();
    chk_irq(1'b1, "R5");
    repeat (3) step();
    chk_irq(1'b1, "R9");
    do_read(A_STS, 16'h0004, "R3");
    chk_irq(1'b0, "R7");
    alarm[2] = 1'b0; step();
    chk_irq(1'b1, "R5");
    do_read(A_STS, 16'h0004, "R4");
    chk_irq(1'b0, "R7");

    // R6: per-bit mask blocks remote alarm
    do_write(A_MSK, 7'h77);
    alarm[3] = 1'b1; step();
    chk_irq(1'b0, "R6");
    do_read(A_STS, 16'h0008, "R3");
    alarm[3] = 1'b0; step();
    chk_irq(1'b0, "R6");
    do_read(A_STS, 16'h0008, "R4");
    do_read(A_STS, 16'h0000, "R4");

    // R6: master mask blocks idle detect
    do_write(A_MSK, 7'h7F);
    do_write(A_MST, 7'h00);
    alarm[4] = 1'b1; step();
    chk_irq(1'b0, "R6");
    alarm[4] = 1'b0; step();
    do_read(A_STS, 16'h0010, "R3");
    do_write(A_MST, 7'h01);
    step();
    chk_irq(1'b0, "R6");

    // R7: change in the same cycle as a status read is kept
    alarm[5] = 1'b1;
    do_read(A_STS, 16'h0000, "R7");
    chk_irq(1'b1, "R7");
    repeat (2) step();
    chk_irq(1'b1, "R9");
    do_read(A_STS, 16'h0020, "R7");
    chk_irq(1'b0, "R7");
    alarm[5] = 1'b0; step();
    chk_irq(1'b1, "R5");
    do_read(A_STS, 16'h0020, "R4");
    chk_irq(1'b0, "R7");

    // R2: all bit positions at once
    alarm = 7'h7F; step();
    chk_irq(1'b1, "R5");
    alarm = 7'h00; step();
    do_read(A_STS, 16'h007F, "R2");
    do_read(A_STS, 16'h0000, "R4");
    chk_irq(1'b0, "R7");

    repeat (3) step();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d reads got no data exp 0 left", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule